// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This unit connects a 32-bit register datapath to a data memory that is organised as 32-bit words but addressed by byte. For each request it adds a sign-extended 16-bit displacement to a base register value to form the effective address. It then presents the word-aligned address to memory. For stores it moves the low bits of the source value into the correct byte lanes and raises the matching byte-enables. For loads it picks the addressed byte or halfword out of the returned word and sign-extends it to 32 bits.

Lanes are big-endian: byte offset 0 within a word is bits 31:24, and offset 3 is bits 7:0. Requests arrive on a valid/ready channel. A request that passes the alignment check goes straight to the memory channel, and the memory's ready becomes the request ready, so memory back-pressure stalls the requester in the same cycle. While `req_valid` is high and `req_ready` is low, the requester must hold every request field steady.

A misaligned request is flagged and consumed in one cycle without touching memory. The memory returns read data exactly one cycle after it accepts a read. The load result is presented for that one cycle and cannot be stalled.

Top module: `lsu_core`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits, wrapping modulo 2^32. `mem_addr` is that address with its two low bits forced to zero.
- R2: A word store (`req_size`=2, or the unused code 3) drives `mem_be`=4'b1111 and places the whole source value on `mem_wdata`.
- R3: A halfword store (`req_size`=1) drives `mem_be`=4'b1100 at byte offset 0 and 4'b0011 at offset 2. It places source bits 15:0 on both halves of `mem_wdata`.
- R4: A byte store (`req_size`=0) raises exactly one enable: `mem_be[3-k]` for byte offset k. It places source bits 7:0 in all four lanes, so source bits 31:8 have no effect on memory.
- R5: One cycle after a word load is accepted, `rsp_data` equals `mem_rdata`.
- R6: A halfword load returns bits 31:16 of the memory word at offset 0 and bits 15:0 at offset 2, sign-extended to 32 bits.
- R7: A byte load returns bits (31-8k):(24-8k) of the memory word for byte offset k, sign-extended to 32 bits.
- R8: A halfword with address bit 0 set, or a word with either low address bit set, is misaligned. For such a request `req_misalign` is high, `mem_valid` is low and `req_ready` is high. Memory is not written and no load response follows.
- R9: For an aligned request, `req_ready` equals `mem_ready`. While `mem_ready` is low, no request is taken.
- R10: `rsp_valid` is high in exactly the cycle after the memory accepts a read, and at no other time. `mem_we` equals `req_store`, and `mem_be` is zero for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high with req_valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word (3 treated as word) |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source value |
| req_misalign | output | 1 | Current request is misaligned |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_we | output | 1 | Write strobe |
| mem_be | output | 4 | Byte-enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, valid one cycle after a read is accepted |
| rsp_valid | output | 1 | Load result present |
| rsp_data | output | 32 | Extended load result |

## Verification
The bound checker checks on every cycle that the enable count matches the access size. It also checks that memory never sees an unaligned address or a misaligned request, that loads carry no enables, and that a response follows each accepted read and appears at no other time. Only the bench scenarios can show that the right bytes arrive. Its reference byte array confirms that stored lanes land at the correct big-endian offsets and that loads return correctly sign-extended values. It also confirms that suppressed misaligned stores leave memory unchanged and that a stalled request is held and then completes.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsu_agen.sv
`timescale 1ns/1ps
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic              misal
);
  localparam int EXT_W = ADDR_W - DISP_W;

  assign ea = base + {{EXT_W{disp[DISP_W-1]}}, disp};

  always_comb begin
    unique case (size)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = ea[0];
      default: misal = |ea[OFF_W-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
`timescale 1ns/1ps
module lsu_store_steer
  import lsu_pkg::*;
(
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   off,
  input  logic [WORD_W-1:0]  src,
  output logic [LANES-1:0]   be,
  output logic [WORD_W-1:0]  wdata
);
  localparam int HALF_W = WORD_W / 2;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        be    = {1'b1, {(LANES-1){1'b0}}} >> off;
        wdata = {LANES{src[7:0]}};
      end
      SZ_HALF: begin
        be    = off[1] ? 4'b0011 : 4'b1100;
        wdata = {2{src[HALF_W-1:0]}};
      end
      default: begin
        be    = {LANES{1'b1}};
        wdata = src;
      end
    endcase
  end
endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
module lsu_load_extract
  import lsu_pkg::*;
(
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   off,
  input  logic [WORD_W-1:0]  rdata,
  output logic [WORD_W-1:0]  data
);
  localparam int HALF_W = WORD_W / 2;

  logic [7:0]        lane_byte [LANES];
  logic [HALF_W-1:0] half_sel;
  logic [7:0]        byte_sel;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_byte[k] = rdata[WORD_W-1-8*k -: 8];
  end

  assign byte_sel = lane_byte[off];
  assign half_sel = off[1] ? rdata[HALF_W-1:0] : rdata[WORD_W-1:HALF_W];

  always_comb begin
    unique case (size)
      SZ_BYTE: data = {{(WORD_W-8){byte_sel[7]}}, byte_sel};
      SZ_HALF: data = {{HALF_W{half_sel[HALF_W-1]}}, half_sel};
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_core.sv
`timescale 1ns/1ps
module lsu_core
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [31:0]       req_wdata,
  output logic              req_misalign,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data
);
  acc_size_e         size_in;
  logic [ADDR_W-1:0] ea;
  logic              misal;
  logic [LANES-1:0]  st_be;
  logic [WORD_W-1:0] st_wdata;
  logic              rd_fire;
  logic [OFF_W-1:0]  off_q;
  acc_size_e         size_q;

  assign size_in = acc_size_e'(req_size);

  lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .base  (req_base),
    .disp  (req_disp),
    .size  (size_in),
    .ea    (ea),
    .misal (misal)
  );

  lsu_store_steer u_steer (
    .size  (size_in),
    .off   (ea[OFF_W-1:0]),
    .src   (req_wdata),
    .be    (st_be),
    .wdata (st_wdata)
  );

  assign mem_valid    = req_valid & ~misal;
  assign req_ready    = misal | mem_ready;
  assign req_misalign = req_valid & misal;
  assign mem_addr     = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_we       = req_store;
  assign mem_be       = req_store ? st_be : '0;
  assign mem_wdata    = st_wdata;
  assign rd_fire      = mem_valid & mem_ready & ~req_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      off_q     <= '0;
      size_q    <= SZ_WORD;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        off_q  <= ea[OFF_W-1:0];
        size_q <= size_in;
      end
    end
  end

  lsu_load_extract u_extract (
    .size  (size_q),
    .off   (off_q),
    .rdata (mem_rdata),
    .data  (rsp_data)
  );
endmodule

// File: rtl/lsu_core_chk.sv
`timescale 1ns/1ps
module lsu_core_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_store,
  input logic [1:0]        req_size,
  input logic              req_misalign,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [3:0]        mem_be,
  input logic              rsp_valid
);
  // R1
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  // R2
  word_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && req_size[1]) |-> mem_be == 4'b1111);

  // R3
  half_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && req_size == 2'd1) |-> $countones(mem_be) == 2);

  // R4
  byte_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && req_size == 2'd0) |-> $countones(mem_be) == 1);

  // R8
  misalign_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_misalign |-> (!mem_valid && req_ready));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_misalign && !mem_ready) |-> !req_ready);

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> rsp_valid);

  // R10
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_ready && !mem_we) |=> !rsp_valid);

  // R10
  load_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !req_store) |-> mem_be == 4'b0000);
endmodule

bind lsu_core lsu_core_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/lsu_core_test.sv
`timescale 1ns/1ps
module lsu_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_wdata = '0;
  logic        req_misalign;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] words [64];
  logic [7:0]  refb  [256];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  lsu_core uut (.*);

  // bench memory: big-endian lanes, read data one cycle after accept
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        for (int j = 0; j < 4; j++)
          if (mem_be[3-j]) words[mem_addr[7:2]][31-8*j -: 8] <= mem_wdata[31-8*j -: 8];
      end else begin
        mem_rdata <= words[mem_addr[7:2]];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected load results
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected response", rsp_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  function automatic logic [31:0] ref_load(input logic [1:0] sz, input logic [7:0] a);
    logic [15:0] h;
    case (sz)
      2'd0: return {{24{refb[a][7]}}, refb[a]};
      2'd1: begin
        h = {refb[a], refb[8'(a+1)]};
        return {{16{h[15]}}, h};
      end
      default: return {refb[a], refb[8'(a+1)], refb[8'(a+2)], refb[8'(a+3)]};
    endcase
  endfunction

  task automatic do_req(input bit st, input logic [1:0] sz, input logic [31:0] base,
                        input logic [15:0] disp, input logic [31:0] wd, input bit stall);
    logic [31:0] ea;
    logic [7:0]  a;
    bit          mis;
    logic [3:0]  ebe;
    logic [31:0] ewd;
    ea  = base + {{16{disp[15]}}, disp};
    a   = ea[7:0];
    mis = (sz == 2'd1) ? ea[0] : (sz == 2'd0) ? 1'b0 : (ea[1:0] != 2'b00);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz;
    req_base = base; req_disp = disp; req_wdata = wd;
    mem_ready = !stall;
    #1;
    if (stall) begin
      check(req_ready == 1'b0, "R9 ready low under stall", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
      check(mem_valid == 1'b1, "R9 request held", {31'b0, mem_valid}, 32'h1);
      mem_ready = 1'b1;
      #1;
      check(req_ready == 1'b1, "R9 ready follows memory", {31'b0, req_ready}, 32'h1);
    end
    check(req_misalign == mis, "R8 misalign flag", {31'b0, req_misalign}, {31'b0, mis});
    if (mis) begin
      check(!mem_valid && req_ready, "R8 suppressed", {30'b0, mem_valid, req_ready}, 32'h1);
    end else begin
      check(mem_addr == {ea[31:2], 2'b00}, "R1 address", mem_addr, {ea[31:2], 2'b00});
      if (st) begin
        case (sz)
          2'd0: begin
            ebe = (ea[1:0] == 0) ? 4'h8 : (ea[1:0] == 1) ? 4'h4 : (ea[1:0] == 2) ? 4'h2 : 4'h1;
            ewd = {wd[7:0], wd[7:0], wd[7:0], wd[7:0]};
            check(mem_be == ebe && mem_wdata == ewd, "R4 byte store lanes", {mem_be, mem_wdata[27:0]}, {ebe, ewd[27:0]});
            refb[a] = wd[7:0];
          end
          2'd1: begin
            ebe = ea[1] ? 4'h3 : 4'hC;
            ewd = {wd[15:0], wd[15:0]};
            check(mem_be == ebe && mem_wdata == ewd, "R3 half store lanes", {mem_be, mem_wdata[27:0]}, {ebe, ewd[27:0]});
            refb[a] = wd[15:8]; refb[8'(a+1)] = wd[7:0];
          end
          default: begin
            check(mem_be == 4'hF && mem_wdata == wd, "R2 word store lanes", mem_wdata, wd);
            refb[a] = wd[31:24]; refb[8'(a+1)] = wd[23:16];
            refb[8'(a+2)] = wd[15:8]; refb[8'(a+3)] = wd[7:0];
          end
        endcase
      end else begin
        check(mem_be == 4'h0 && !mem_we, "R10 load has no enables", {27'b0, mem_we, mem_be}, 32'h0);
        exp_q.push_back(ref_load(sz, a));
        tag_q.push_back(sz == 2'd0 ? "R7 byte load" : sz == 2'd1 ? "R6 half load" : "R5 word load");
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      words[i] = (i * 32'h1357_9BDF) ^ 32'h80C4_3A11;
      for (int k = 0; k < 4; k++) refb[4*i+k] = words[i][31-8*k -: 8];
    end
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && mem_valid == 1'b0, "R10 reset state", {30'b0, rsp_valid, mem_valid}, 32'h0);
    rst_n = 1'b1;
    // R1 R5: positive and negative displacement, word loads
    do_req(0, 2'd2, 32'h10, 16'h0020, 0, 0);
    do_req(0, 2'd2, 32'h40, 16'hFFFC, 0, 0);
    // R2 R3 R4: stores, upper source bits must not land for byte store
    do_req(1, 2'd0, 32'h40, 16'h0001, 32'h1234_56A5, 0);
    do_req(1, 2'd0, 32'h40, 16'h0003, 32'hFFFF_FF37, 0);
    do_req(1, 2'd1, 32'h40, 16'h0002, 32'hBEEF_8001, 0);
    do_req(1, 2'd1, 32'h60, 16'h0000, 32'h0000_7ACE, 0);
    do_req(1, 2'd2, 32'h58, 16'hFFF8, 32'hC001_D00D, 0);
    do_req(1, 2'd3, 32'h70, 16'h0000, 32'h0102_0304, 0);
    // R5 R6 R7: loads back, every byte offset and both halves
    do_req(0, 2'd2, 32'h40, 16'h0000, 0, 0);
    do_req(0, 2'd0, 32'h40, 16'h0001, 0, 0);
    do_req(0, 2'd0, 32'h40, 16'h0003, 0, 0);
    do_req(0, 2'd0, 32'h40, 16'h0000, 0, 0);
    do_req(0, 2'd0, 32'h40, 16'h0002, 0, 0);
    do_req(0, 2'd1, 32'h40, 16'h0002, 0, 0);
    do_req(0, 2'd1, 32'h60, 16'h0000, 0, 0);
    do_req(0, 2'd1, 32'h40, 16'h0000, 0, 0);
    do_req(0, 2'd2, 32'h50, 16'h0000, 0, 0);
    do_req(0, 2'd2, 32'h70, 16'h0000, 0, 0);
    // R8: misaligned requests, memory must stay unchanged
    do_req(0, 2'd2, 32'h40, 16'h0002, 0, 0);
    do_req(1, 2'd1, 32'h44, 16'h0001, 32'hDEAD_BEEF, 0);
    do_req(1, 2'd2, 32'h48, 16'h0003, 32'hDEAD_BEEF, 0);
    do_req(0, 2'd2, 32'h44, 16'h0000, 0, 0);
    do_req(0, 2'd2, 32'h48, 16'h0004, 0, 0);
    // R9: stalled load and stalled store
    do_req(0, 2'd0, 32'h20, 16'h0002, 0, 1);
    do_req(1, 2'd2, 32'h30, 16'h0000, 32'h5555_AAAA, 1);
    do_req(0, 2'd2, 32'h30, 16'h0000, 0, 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule